// File: doc/BRIEF.md
# Dual-Chip-Select Static RAM Model

This block is a synthesizable model of a byte-wide asynchronous static RAM. A test environment uses it as the target of an external memory interface. All pins are asynchronous. The model samples them on a fast local clock through a two-flop synchronizer and rebuilds the device behaviour from the sampled levels.

The device is selected only when the active-low select `cs1_ni` is low and the active-high select `cs2_i` is high. A selected device is in one of three modes:

- Output disabled, with the bus released.
- Read, with the addressed word driven.
- Write, with the bus used as an input.

A write window opens at the last of three events: `cs1_ni` falling, `cs2_i` rising or `we_ni` falling. It closes at the first of the matching de-assertions. The word and address sampled in the last cycle before the close are committed to the array on the closing edge.

The array is organised as rows by column groups. The high `ROW_W` address bits pick the row and the low `COL_W` bits pick the word within it. `ROW_W=10` and `COL_W=7` give the full 128K x 8 part. The defaults are kept small. The bus tristate sits in the pad ring outside this block, so the bus appears as the pair `dq_i`/`dq_o` plus the drive enable `dq_oe_o`.

Top module: `dcs_sram`

## Requirements
- R1: With `cs1_ni` high, `dq_oe_o` is low (bus high impedance), whatever `oe_ni` and `we_ni` are.
- R2: With `cs2_i` low, `dq_oe_o` is low, whatever `oe_ni` and `we_ni` are.
- R3: When the device is selected with `oe_ni` high and `we_ni` high, `dq_oe_o` is low.
- R4: When the device is selected with `oe_ni` low and `we_ni` high, `dq_oe_o` is high and `dq_o` carries the stored word at `addr_i`.
- R5: When the device is selected and `we_ni` is low, `dq_oe_o` is low even if `oe_ni` is low, and the word on `dq_i` is written.
- R6: A write window closed by `we_ni` rising stores the data that was held through the close. Data changed after the close is not stored.
- R7: A write window closed by `cs1_ni` rising stores its data once. A later rise of `we_ni` while deselected writes nothing further.
- R8: A write window closed by `cs2_i` falling stores its data.
- R9: `we_ni` pulses while the device is deselected leave every stored word unchanged.
- R10: Pin changes take effect on `dq_oe_o` two clocks later. A new read address reaches `dq_o` three clocks after it is applied. Until then, `dq_o` keeps the previous word.
- R11: While `rst_ni` is low and after its release, with idle pins, `dq_oe_o` is low.
- R12: Address 0 and the highest address (all `ROW_W+COL_W` bits set) hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ROW_W+COL_W | Word address: row in high bits, column in low bits |
| dq_i | input | DATA_W | Bus value seen at the pad |
| dq_o | output | DATA_W | Read data toward the pad |
| dq_oe_o | output | 1 | Pad drive enable; low means high impedance |

## Verification
A pin change made between clock edges reaches the synchronized copy on the second rising edge, and `dq_oe_o` follows at once. Read data adds a third edge for the array register. A commit lands on the third edge after the closing pin change. The driver applies stimulus on falling edges and waits exactly three rising edges before it queues the expected enable and data. The monitor compares them at the next falling edge. For R10, the driver queues one check after the second edge to see the old word still on the bus, and one after the third edge to see the new word.

// File: rtl/dcs_sram_pkg.sv
package dcs_sram_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL,
    MODE_OFF,
    MODE_READ,
    MODE_WRITE
  } dcs_mode_e;
endpackage

// File: rtl/dcs_sram_sync.sv
module dcs_sram_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dcs_sram_ctrl.sv
module dcs_sram_ctrl
  import dcs_sram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs1_n_i,
  input  logic              cs2_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output dcs_mode_e         mode_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic sel, win, win_q;

  assign sel = !cs1_n_i && cs2_i;
  // window open = overlap of both selects and write enable
  assign win = sel && !we_n_i;

  always_comb begin
    if (!sel)        mode_o = MODE_DESEL;
    else if (!we_n_i) mode_o = MODE_WRITE;
    else if (!oe_n_i) mode_o = MODE_READ;
    else             mode_o = MODE_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      win_q <= win;
      if (win) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end
  end

  // one pulse per window; needs a prior selected cycle, so deselected WE edges never write
  assign commit_o = win_q && !win;
endmodule

// File: rtl/dcs_sram_array.sv
module dcs_sram_array #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ROW_W+COL_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [ROW_W+COL_W-1:0]  raddr_i,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int ADDR_W = ROW_W + COL_W;

  logic [DATA_W-1:0] mem [ROWS][COLS];

  logic [ROW_W-1:0] w_row, r_row;
  logic [COL_W-1:0] w_col, r_col;

  assign w_row = waddr_i[ADDR_W-1:COL_W];
  assign w_col = waddr_i[COL_W-1:0];
  assign r_row = raddr_i[ADDR_W-1:COL_W];
  assign r_col = raddr_i[COL_W-1:0];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[w_row][w_col] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[r_row][r_col];
  end
endmodule

// File: rtl/dcs_sram.sv
module dcs_sram
  import dcs_sram_pkg::*;
#(
  parameter int ROW_W       = 4,
  parameter int COL_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs1_ni,
  input  logic                   cs2_i,
  input  logic                   oe_ni,
  input  logic                   we_ni,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      dq_i,
  output logic [DATA_W-1:0]      dq_o,
  output logic                   dq_oe_o
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BUS_W  = 4 + ADDR_W + DATA_W;
  // idle pins: cs1 high, cs2 low, oe high, we high
  localparam logic [BUS_W-1:0] SYNC_RST = {4'b1011, {(ADDR_W+DATA_W){1'b0}}};

  logic [BUS_W-1:0]  raw, syn;
  logic              s_cs1_n, s_cs2, s_oe_n, s_we_n;
  logic [ADDR_W-1:0] s_addr, wr_addr;
  logic [DATA_W-1:0] s_data, wr_data;
  dcs_mode_e         mode;
  logic              commit;

  assign raw = {cs1_ni, cs2_i, oe_ni, we_ni, addr_i, dq_i};

  dcs_sram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {s_cs1_n, s_cs2, s_oe_n, s_we_n, s_addr, s_data} = syn;

  dcs_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs1_n_i  (s_cs1_n),
    .cs2_i    (s_cs2),
    .oe_n_i   (s_oe_n),
    .we_n_i   (s_we_n),
    .addr_i   (s_addr),
    .data_i   (s_data),
    .mode_o   (mode),
    .commit_o (commit),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  dcs_sram_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (commit),
    .waddr_i(wr_addr),
    .wdata_i(wr_data),
    .raddr_i(s_addr),
    .rdata_o(dq_o)
  );

  assign dq_oe_o = (mode == MODE_READ);
endmodule

// File: rtl/dcs_sram_chk.sv
module dcs_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs1_ni,
  input logic cs2_i,
  input logic oe_ni,
  input logic we_ni,
  input logic dq_oe_o
);
  logic [1:0] up_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              up_cnt <= '0;
    else if (up_cnt != 2'd3)  up_cnt <= up_cnt + 2'd1;
  end

  a_r1_cs1_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs1_ni, 2) |-> !dq_oe_o);

  a_r2_cs2_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs2_i, 2) |-> !dq_oe_o);

  a_r3_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_ni && we_ni, 2) |-> !dq_oe_o);

  a_r5_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_ni, 2) |-> !dq_oe_o);

  a_r4_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 2'd3 && $past(!cs1_ni && cs2_i && !oe_ni && we_ni, 2)) |-> dq_oe_o);
endmodule

bind dcs_sram dcs_sram_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs1_ni (cs1_ni),
  .cs2_i  (cs2_i),
  .oe_ni  (oe_ni),
  .we_ni  (we_ni),
  .dq_oe_o(dq_oe_o)
);

// File: tb/dcs_sram_test.sv
module dcs_sram_test;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 5;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_MAX = '1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs1_ni = 1'b1, cs2_i = 1'b0, oe_ni = 1'b1, we_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] dq_i = '0, dq_o;
  logic dq_oe_o;

  always #10 clk = ~clk;

  dcs_sram #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs1_ni(cs1_ni), .cs2_i(cs2_i),
    .oe_ni(oe_ni), .we_ni(we_ni), .addr_i(addr_i), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  typedef struct {
    logic              exp_oe;
    logic              chk_d;
    logic [DATA_W-1:0] exp_d;
    string             tag;
  } item_t;

  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (dq_oe_o !== it.exp_oe) begin
        bad++;
        $display("FAIL %s: oe actual=%0b expected=%0b", it.tag, dq_oe_o, it.exp_oe);
      end else if (it.chk_d && dq_o !== it.exp_d) begin
        bad++;
        $display("FAIL %s: data actual=%02h expected=%02h", it.tag, dq_o, it.exp_d);
      end
    end
  end

  task automatic push(input logic oe, input logic chk, input logic [DATA_W-1:0] d, input string tag);
    item_t it;
    it.exp_oe = oe; it.chk_d = chk; it.exp_d = d; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic go_idle();
    cs1_ni = 1'b1; cs2_i = 1'b0; oe_ni = 1'b1; we_ni = 1'b1;
  endtask

  // closer: 0 = we rises, 1 = cs1 rises, 2 = cs2 falls
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int closer);
    @(negedge clk);
    addr_i = a; dq_i = d; cs1_ni = 1'b0; cs2_i = 1'b1; oe_ni = 1'b1; we_ni = 1'b0;
    repeat (4) @(negedge clk);
    case (closer)
      0:       we_ni  = 1'b1;
      1:       cs1_ni = 1'b1;
      default: cs2_i  = 1'b0;
    endcase
    @(negedge clk);
    dq_i = ~d;  // changed after close: must not be stored
    repeat (3) @(negedge clk);
    go_idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    addr_i = a; cs1_ni = 1'b0; cs2_i = 1'b1; oe_ni = 1'b0; we_ni = 1'b1;
    repeat (3) @(posedge clk);
    push(1'b1, 1'b1, d, tag);
    @(negedge clk);
  endtask

  task automatic hz(input logic c1, input logic c2, input logic oe, input logic we, input string tag);
    @(negedge clk);
    cs1_ni = c1; cs2_i = c2; oe_ni = oe; we_ni = we;
    repeat (3) @(posedge clk);
    push(1'b0, 1'b0, '0, tag);
    @(negedge clk);
    go_idle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    push(1'b0, 1'b0, '0, "R11 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    push(1'b0, 1'b0, '0, "R11 after reset");
    @(negedge clk);

    wr(9'd5, 8'h11, 0);      // R6
    wr(9'd6, 8'h22, 1);      // R7
    wr(9'd7, 8'h33, 2);      // R8
    wr(A_MAX, 8'hA5, 0);     // R12
    wr(9'd0, 8'h5A, 1);      // R12

    rd(9'd5, 8'h11, "R6 we-closed write");
    rd(9'd6, 8'h22, "R7 cs1-closed write");
    rd(9'd7, 8'h33, "R8 cs2-closed write");
    rd(A_MAX, 8'hA5, "R12 top address");
    rd(9'd0, 8'h5A, "R12 address zero");
    rd(9'd7, 8'h33, "R4 read again");

    hz(1'b1, 1'b1, 1'b0, 1'b1, "R1 cs1 high read pins");
    hz(1'b1, 1'b1, 1'b0, 1'b0, "R1 cs1 high we low");
    hz(1'b0, 1'b0, 1'b0, 1'b1, "R2 cs2 low read pins");
    hz(1'b0, 1'b1, 1'b1, 1'b1, "R3 output disabled");

    @(negedge clk);
    addr_i = 9'd9; dq_i = 8'hC3;
    hz(1'b0, 1'b1, 1'b0, 1'b0, "R5 write with oe low");
    rd(9'd9, 8'hC3, "R5 data stored");

    // R9: WE pulses while deselected
    @(negedge clk);
    addr_i = 9'd5; dq_i = 8'hFF; cs1_ni = 1'b1; cs2_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      we_ni = 1'b0; repeat (3) @(negedge clk);
      we_ni = 1'b1; repeat (3) @(negedge clk);
    end
    @(negedge clk);
    cs1_ni = 1'b0; cs2_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      we_ni = 1'b0; repeat (3) @(negedge clk);
      we_ni = 1'b1; repeat (3) @(negedge clk);
    end
    go_idle();
    repeat (4) @(negedge clk);
    rd(9'd5, 8'h11, "R9 no write while deselected");

    // R10: old word held while the new address is pending
    addr_i = 9'd6;
    repeat (2) @(posedge clk);
    push(1'b1, 1'b1, 8'h11, "R10 old word held");
    @(posedge clk);
    push(1'b1, 1'b1, 8'h22, "R10 new word after three clocks");
    @(negedge clk);
    go_idle();
    repeat (4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule